// File: doc/BRIEF.md
# Serial Port Expander Controller

This controller gives a host six bidirectional 8-bit ports while using only a handful of pins. The ports live in two daisy-chained banks of external shift registers. An output bank holds six data registers followed by one enable register. An input bank holds six registers that are loaded in parallel from the port pins. All traffic to and from both banks is bit-serial, on one shift clock that the controller generates.

The host issues one of three commands. A write replaces all six output bytes. A direction command replaces the per-port enables. A read captures all six input bytes. A write or a direction command starts a full 56-bit update of the output bank, which ends with a latch strobe. A read pulses a parallel-load strobe and then shifts 48 bits back in. The controller stays busy for the whole transfer and pulses a done flag when the transfer ends.

Top module: `sr_port_expander`

## Requirements
- R1: After reset, busy, done, sclk and out_latch are 0 and in_load_n is 1. The stored output bytes are all zero and every port enable is cleared.
- R2: A write command (cmd_op = 2'b01) stores cmd_data as the six output bytes, with port p at cmd_data[8p+7:8p], and starts an output update.
- R3: An output update shifts 56 bits MSB first. The enable byte goes first, then the bytes of ports 5, 4, 3, 2 and 1, and the byte of port 0 goes last. One out_latch pulse of exactly one cycle follows the last shift clock.
- R4: A direction command (cmd_op = 2'b10) stores cmd_data[5:0] as the enables (bit p = 1 drives port p) and starts an update. The two upper bits of the enable byte are always sent as 0, and the stored data bytes are kept.
- R5: A read command (cmd_op = 2'b11) pulls in_load_n low for exactly one cycle and then applies 48 shift clocks. The first 8 bits received are port 0, MSB first, then ports 1 to 5. When done pulses, rd_data[8p+7:8p] holds port p.
- R6: sclk is high for DIV system cycles and low for DIV cycles. sdo changes only while sclk is low, so it is stable at every rising edge, and sdi is sampled at the rising edge.
- R7: busy rises in the cycle after a command is accepted and stays high until after the final strobe. A command presented while busy is ignored, and so is cmd_op = 2'b00.
- R8: done is a single-cycle pulse, raised in the cycle where busy has just returned to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 write, 10 direction, 11 read, 00 none |
| cmd_data | input | 48 | Output bytes, or enables in bits 5:0 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | 48 | Captured input bytes, port p at [8p+7:8p] |
| sclk | output | 1 | Shift clock to both chains |
| sdo | output | 1 | Serial data into the output chain |
| out_latch | output | 1 | Output chain latch strobe |
| in_load_n | output | 1 | Active-low parallel load of the input chain |
| sdi | input | 1 | Serial data from the input chain |

## Verification
The bench builds the controller with DIV = 2. This keeps each update near 230 cycles, so dozens of mixed random commands fit in the run while a full sclk period is still four cycles. With that period the high and low phases can be told apart, and the bench can measure that sdo holds across each rising edge. Behavioural models of both external chains sit beside the design, so the bench can compare the latched 56-bit image and the reordered read bytes directly. Commands injected mid-transfer exercise the ignore rule.

// File: rtl/sr_port_expander.sv
module sr_port_expander #(
  parameter int PORTS = 6,
  parameter int PW    = 8,
  parameter int DIV   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [PORTS*PW-1:0]   cmd_data,
  output logic                  busy,
  output logic                  done,
  output logic [PORTS*PW-1:0]   rd_data,
  output logic                  sclk,
  output logic                  sdo,
  output logic                  out_latch,
  output logic                  in_load_n,
  input  logic                  sdi
);
  localparam int DW  = PORTS * PW;
  localparam int CW  = DW + PW;
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BCW = $clog2(CW + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_LATCH} st_t;

  st_t              state;
  logic [DCW-1:0]   dcnt;
  logic [BCW-1:0]   bcnt;
  logic             is_rd;
  logic             sclk_r;
  logic             done_r;
  logic [CW-1:0]    tx_sh;
  logic [DW-1:0]    rx_sh;
  logic [DW-1:0]    rx_ord;
  logic [DW-1:0]    data_q;
  logic [DW-1:0]    rd_q;
  logic [PORTS-1:0] en_q;

  wire             accept = cmd_valid && (state == S_IDLE) && (cmd_op != 2'b00);
  wire             half   = (dcnt == DCW'(DIV - 1));
  wire [BCW-1:0]   last   = is_rd ? BCW'(DW - 1) : BCW'(CW - 1);

  for (genvar p = 0; p < PORTS; p++) begin : g_ord
    assign rx_ord[p*PW +: PW] = rx_sh[DW-PW*(p+1) +: PW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      dcnt   <= '0;
      bcnt   <= '0;
      is_rd  <= 1'b0;
      sclk_r <= 1'b0;
      done_r <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      data_q <= '0;
      rd_q   <= '0;
      en_q   <= '0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          dcnt   <= '0;
          bcnt   <= '0;
          sclk_r <= 1'b0;
          case (cmd_op)
            2'b01: begin
              data_q <= cmd_data;
              tx_sh  <= {{(PW-PORTS){1'b0}}, en_q, cmd_data};
              is_rd  <= 1'b0;
              state  <= S_SHIFT;
            end
            2'b10: begin
              en_q  <= cmd_data[PORTS-1:0];
              tx_sh <= {{(PW-PORTS){1'b0}}, cmd_data[PORTS-1:0], data_q};
              is_rd <= 1'b0;
              state <= S_SHIFT;
            end
            default: begin
              is_rd <= 1'b1;
              state <= S_LOAD;
            end
          endcase
        end
        S_LOAD: state <= S_SHIFT;
        S_SHIFT: begin
          if (half) begin
            dcnt <= '0;
            if (!sclk_r) begin
              sclk_r <= 1'b1;
              if (is_rd) rx_sh <= {rx_sh[DW-2:0], sdi};
            end else begin
              sclk_r <= 1'b0;
              tx_sh  <= {tx_sh[CW-2:0], 1'b0};
              bcnt   <= bcnt + 1'b1;
              if (bcnt == last) begin
                if (is_rd) begin
                  state  <= S_IDLE;
                  done_r <= 1'b1;
                  rd_q   <= rx_ord;
                end else begin
                  state <= S_LATCH;
                end
              end
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        S_LATCH: begin
          state  <= S_IDLE;
          done_r <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = done_r;
  assign rd_data   = rd_q;
  assign sclk      = sclk_r;
  assign sdo       = tx_sh[CW-1];
  assign out_latch = (state == S_LATCH);
  assign in_load_n = (state != S_LOAD);

endmodule

// File: rtl/sr_port_expander_chk.sv
module sr_port_expander_chk #(
  parameter int CW = 56
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdo,
  input logic out_latch,
  input logic in_load_n
);
  logic       sclk_q;
  logic [15:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_q <= sclk;
      if (!busy)                rises <= '0;
      else if (sclk && !sclk_q) rises <= rises + 1'b1;
    end
  end

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(sdo)); // R6
  AST_LATCH_ONE: assert property (@(posedge clk) disable iff (!rst_n) out_latch |=> !out_latch); // R3
  AST_LATCH_COUNT: assert property (@(posedge clk) disable iff (!rst_n) out_latch |-> (rises == 16'(CW))); // R3
  AST_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n) !in_load_n |=> in_load_n); // R5
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (out_latch || !in_load_n) |-> busy); // R7
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk); // R7
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $fell(busy))); // R8
endmodule

bind sr_port_expander sr_port_expander_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(sclk),
  .sdo(sdo), .out_latch(out_latch), .in_load_n(in_load_n)
);

// File: tb/sr_port_expander_test.sv
`timescale 1ns/1ps
module sr_port_expander_test;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [47:0] cmd_data = '0;
  logic        busy, done, sclk, sdo, out_latch, in_load_n, sdi;
  logic [47:0] rd_data;

  sr_port_expander #(.PORTS(6), .PW(8), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .done(done), .rd_data(rd_data),
    .sclk(sclk), .sdo(sdo), .out_latch(out_latch), .in_load_n(in_load_n),
    .sdi(sdi)
  );

  always #2.5 clk = ~clk;

  logic [47:0] pins = '0;
  logic [55:0] ochain = '0, olat = '0;
  logic [47:0] ichain = '0;
  logic        sclk_p = 1'b0;
  int          gap = 0, bad_period = 0, n_latch = 0, n_load = 0;

  function automatic logic [47:0] pack_in(input logic [47:0] v);
    logic [47:0] r;
    for (int p = 0; p < 6; p++) r[48-8*(p+1) +: 8] = v[8*p +: 8];
    return r;
  endfunction

  function automatic logic [55:0] exp_img(input logic [5:0] en, input logic [47:0] d);
    return {2'b00, en, d};
  endfunction

  assign sdi = ichain[47];

  always @(posedge clk) begin
    sclk_p <= sclk;
    if (out_latch) begin olat <= ochain; n_latch <= n_latch + 1; end
    if (!in_load_n) begin ichain <= pack_in(pins); n_load <= n_load + 1; end
    else if (sclk && !sclk_p) ichain <= {ichain[46:0], 1'b0};
    if (sclk && !sclk_p) begin
      ochain <= {ochain[54:0], sdo};
      if (gap != 2*DIV && busy && gap < 2*DIV + 2 && gap != 0) bad_period <= bad_period + 1;
      gap <= 1;
    end else if (!busy) gap <= 0;
    else if (gap != 0) gap <= gap + 1;
  end

  int n_chk = 0, n_fail = 0;
  logic [47:0] exp_data = '0;
  logic [5:0]  exp_en = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [47:0] d, input bit inject);
    int lat0, ld0, bp0, wd;
    lat0 = n_latch; ld0 = n_load; bp0 = bad_period;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 2'b00) begin
      chk(busy == 1'b0, "R7 op00 ignored", 64'(busy), 64'd0);
      return;
    end
    chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
    if (op == 2'b01) exp_data = d;
    if (op == 2'b10) exp_en = d[5:0];
    if (inject) begin
      cmd_valid = 1'b1;
      cmd_op = 2'($urandom_range(1, 3));
      cmd_data = {$urandom, $urandom};
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wd = 0;
    while (!done && wd < 2000) begin @(negedge clk); wd++; end
    chk(done == 1'b1, "R8 done seen", 64'(done), 64'd1);
    chk(busy == 1'b0, "R8 busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", 64'(done), 64'd0);
    chk(bad_period == bp0, "R6 sclk period", 64'(bad_period - bp0), 64'd0);
    if (op == 2'b11) begin
      chk(rd_data == pins, "R5 read bytes", 64'(rd_data), 64'(pins));
      chk(n_load - ld0 == 1, "R5 one load strobe", 64'(n_load - ld0), 64'd1);
    end else begin
      chk(olat == exp_img(exp_en, exp_data), op == 2'b01 ? "R2 R3 latched image" : "R4 latched image",
          64'(olat), 64'(exp_img(exp_en, exp_data)));
      chk(n_latch - lat0 == 1, "R3 one latch strobe", 64'(n_latch - lat0), 64'd1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({busy, done, sclk, out_latch, in_load_n} == 5'b00001, "R1 reset outputs",
        64'({busy, done, sclk, out_latch, in_load_n}), 64'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero data shadow visible through a direction-only update
    run_cmd(2'b10, 48'd0, 1'b0);
    // R1: enables still cleared after first write
    run_cmd(2'b01, 48'h0123_4567_89AB, 1'b0);
    // R4: upper enable bits dropped, data kept
    run_cmd(2'b10, 48'hFFFF_FFFF_FFFF, 1'b0);
    run_cmd(2'b10, 48'h15, 1'b0);
    // R5: directed read patterns
    pins = 48'h8001_FF00_A55A; run_cmd(2'b11, 48'd0, 1'b0);
    pins = 48'hFFFF_FFFF_FFFF; run_cmd(2'b11, 48'd0, 1'b0);
    // R7: command while busy ignored
    run_cmd(2'b01, 48'hDEAD_BEEF_CAFE, 1'b1);
    run_cmd(2'b00, 48'h1111_1111_1111, 1'b0);
    run_cmd(2'b10, 48'h2A, 1'b1);
    for (int i = 0; i < 30; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      pins = {$urandom, $urandom};
      run_cmd(op, {$urandom, $urandom}, 1'($urandom_range(0, 1)));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule